// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel receive port until a host drains them through a small register window. Words enter when the receive path is switched on and the store has room. A host takes words out by reading a fixed data register: each read strobe on that address returns the oldest word and removes it. Reads of any other address have no side effects.

Four active-high "not" level flags describe the fill level: not empty, not almost empty, not almost full and not full. The almost-empty and almost-full points come from one packed threshold register. Two sticky error bits record a word lost to a full store (overrun) and a data read from an empty store (underrun). Each stays set until software writes a one to its position in the status register.

A control register gives a receive enable, a FIFO flush and a whole-block reset. After a whole-block reset the store is unavailable for a programmable number of clocks. During that time control bit 0 reads back as one.

Top module: `rx_word_fifo`

Register addresses on `reg_addr`: 0 control, 1 status, 2 thresholds, 3 data, 4 fill level, 5 depth; other addresses read zero. Control bits: 0 block reset (reads back as busy), 2 FIFO flush (self-clearing, reads 0), 5 receive enable. Status bits: 12 not empty, 13 not almost empty, 14 not almost full, 15 not full, 22 underrun, 23 overrun. Threshold register: almost-empty count in bits 15:0, almost-full count in bits 23:16.

## Requirements
- R1: After `rst_n` is released, the block is empty with both error bits clear. Control reads 0, thresholds read 0x0020_0020 (32 and 32), and the status flags match the level rules for a level of zero.
- R2: `in_ready` is high exactly when control bit 5 is set, the block is not busy and the store is not full. A word is stored on a clock with `in_valid` and `in_ready` both high. Data register reads strobed with `reg_rd` return the stored words in arrival order. Words offered while receive is disabled are dropped without any error.
- R3: The fill-level register reports the stored word count in bits 19:0, and the depth register reports DEPTH in bits 19:0.
- R4: Status bit 12 is 1 when the level is above zero. Status bit 15 is 1 when the level is below DEPTH.
- R5: Status bit 13 is 1 when the level is greater than the almost-empty count (threshold bits 15:0).
- R6: Status bit 14 is 1 when the level plus the almost-full count (threshold bits 23:16) is below DEPTH, that is, when the level is below DEPTH minus that count.
- R7: A word offered while receive is enabled, the block is not busy and the store is full is dropped, and status bit 23 becomes 1. The stored words are unaffected.
- R8: A strobed data read while the store is empty and the block is not busy returns 0, leaves the level at 0 and sets status bit 22.
- R9: Writing a one to status bit 22 or 23 clears that bit. Zeros and all other status bit positions have no effect. An error event in the same clock as its clear leaves the bit set.
- R10: Writing control bit 2 empties the store. The thresholds, the receive enable and both error bits are kept. Bit 2 reads back as 0.
- R11: Writing control bit 0 empties the store, clears both error bits and the receive enable, and restores both thresholds to 32. For the next BUSY_CYCLES clocks, control bit 0 reads 1 and `in_ready` is 0. Data reads in that window return 0 without popping a word or setting underrun.
- R12: A word accepted in the same clock as a strobed data read of a non-empty store leaves the level unchanged. Order is preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A receive word is present on `in_data` |
| in_data | input | DATA_W | Receive word |
| in_ready | output | 1 | The store will take a word this clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Write data; only bits 23:0 are writable anywhere |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The receive source cannot be held off. The checks therefore assume that a word offered while `in_ready` is low is lost, and that `reg_wr` and `reg_rd` are never both high. The bench drives each access in its own clock and changes inputs only on the falling edge. The one exception is the deliberate same-clock cases for R9 and R12, where a receive word coincides with a register access. The fill and drain sweeps run over a 16-deep store, crossing every level under several threshold pairs, including counts above the depth.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_STATUS = 3'd1,
    RA_THRESH = 3'd2,
    RA_DATA   = 3'd3,
    RA_LEVEL  = 3'd4,
    RA_DEPTH  = 3'd5
  } rxf_addr_e;

  localparam int CB_BOARD_RST = 0;
  localparam int CB_FIFO_RST  = 2;
  localparam int CB_RX_EN     = 5;

  localparam int SB_NOT_EMPTY  = 12;
  localparam int SB_NOT_AEMPTY = 13;
  localparam int SB_NOT_AFULL  = 14;
  localparam int SB_NOT_FULL   = 15;
  localparam int SB_UNDERRUN   = 22;
  localparam int SB_OVERRUN    = 23;

  localparam int AE_W      = 16;
  localparam int AF_W      = 8;
  localparam int AF_LSB    = 16;
  localparam int COUNT_W   = 20;
  localparam int THR_RESET = 32;

  typedef struct packed {
    logic not_empty;
    logic not_aempty;
    logic not_afull;
    logic not_full;
  } rxf_flags_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [PW-1:0]     wr_nxt, rd_nxt;

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] level,
  input  logic [AE_W-1:0]  ae_thr,
  input  logic [AF_W-1:0]  af_thr,
  output rxf_flags_t       flags
);

  logic [31:0] lvl_w;
  logic [31:0] af_sum;

  always_comb begin
    lvl_w            = 32'(level);
    af_sum           = lvl_w + 32'(af_thr);
    flags.not_empty  = (lvl_w != 32'd0);
    flags.not_full   = (lvl_w < 32'(DEPTH));
    flags.not_aempty = (lvl_w > 32'(ae_thr));
    flags.not_afull  = (af_sum < 32'(DEPTH));
  end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000,
  localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_status,
  input  logic            wr_thresh,
  input  logic [23:0]     wdata,
  input  logic            overrun_evt,
  input  logic            underrun_evt,
  output logic            rx_en,
  output logic            busy,
  output logic            fifo_clear,
  output logic [AE_W-1:0] ae_thr,
  output logic [AF_W-1:0] af_thr,
  output logic            err_over,
  output logic            err_under
);

  logic [BW-1:0] busy_cnt;
  logic          board_rst;

  assign board_rst  = wr_ctrl && wdata[CB_BOARD_RST];
  assign fifo_clear = wr_ctrl && (wdata[CB_BOARD_RST] || wdata[CB_FIFO_RST]);
  assign busy       = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (board_rst) begin
      busy_cnt <= BW'(BUSY_CYCLES);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      ae_thr <= AE_W'(THR_RESET);
      af_thr <= AF_W'(THR_RESET);
    end else if (board_rst) begin
      rx_en  <= 1'b0;
      ae_thr <= AE_W'(THR_RESET);
      af_thr <= AF_W'(THR_RESET);
    end else begin
      if (wr_ctrl) rx_en <= wdata[CB_RX_EN];
      if (wr_thresh) begin
        ae_thr <= wdata[AE_W-1:0];
        af_thr <= wdata[AF_LSB +: AF_W];
      end
    end
  end

  logic over_clr, under_clr;
  assign over_clr  = wr_status && wdata[SB_OVERRUN];
  assign under_clr = wr_status && wdata[SB_UNDERRUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_over  <= 1'b0;
      err_under <= 1'b0;
    end else if (board_rst) begin
      err_over  <= 1'b0;
      err_under <= 1'b0;
    end else begin
      err_over  <= (err_over  && !over_clr)  || overrun_evt;
      err_under <= (err_under && !under_clr) || underrun_evt;
    end
  end

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 64,
  parameter int BUSY_CYCLES = 1000,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [23:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  generate
    if (DATA_W > 32 || DEPTH < 2 || CNT_W > COUNT_W || BUSY_CYCLES < 1) begin : g_bad_cfg
      $error("rx_word_fifo: unsupported parameter set");
    end
  endgenerate

  logic [CNT_W-1:0]  lvl;
  logic [DATA_W-1:0] head;
  rxf_flags_t        flg;
  logic              rx_en, busy, fifo_clear;
  logic [AE_W-1:0]   ae_thr;
  logic [AF_W-1:0]   af_thr;
  logic              err_over, err_under;

  logic wr_ctrl, wr_status, wr_thresh, rd_data;
  logic fifo_open, push, pop, overrun_evt, underrun_evt;

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_status = reg_wr && (reg_addr == RA_STATUS);
  assign wr_thresh = reg_wr && (reg_addr == RA_THRESH);
  assign rd_data   = reg_rd && (reg_addr == RA_DATA) && !busy;

  assign fifo_open    = rx_en && !busy;
  assign in_ready     = fifo_open && flg.not_full;
  assign push         = in_valid && in_ready && !fifo_clear;
  assign overrun_evt  = in_valid && fifo_open && !flg.not_full && !fifo_clear;
  assign pop          = rd_data && flg.not_empty && !fifo_clear;
  assign underrun_evt = rd_data && !flg.not_empty;

  rxf_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wr_status    (wr_status),
    .wr_thresh    (wr_thresh),
    .wdata        (reg_wdata),
    .overrun_evt  (overrun_evt),
    .underrun_evt (underrun_evt),
    .rx_en        (rx_en),
    .busy         (busy),
    .fifo_clear   (fifo_clear),
    .ae_thr       (ae_thr),
    .af_thr       (af_thr),
    .err_over     (err_over),
    .err_under    (err_under)
  );

  rxf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fifo_clear),
    .push  (push),
    .pop   (pop),
    .wdata (in_data),
    .head  (head),
    .level (lvl)
  );

  rxf_flags #(
    .DEPTH (DEPTH)
  ) u_flags (
    .level  (lvl),
    .ae_thr (ae_thr),
    .af_thr (af_thr),
    .flags  (flg)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CB_BOARD_RST] = busy;
        reg_rdata[CB_RX_EN]     = rx_en;
      end
      RA_STATUS: begin
        reg_rdata[SB_NOT_EMPTY]  = flg.not_empty;
        reg_rdata[SB_NOT_AEMPTY] = flg.not_aempty;
        reg_rdata[SB_NOT_AFULL]  = flg.not_afull;
        reg_rdata[SB_NOT_FULL]   = flg.not_full;
        reg_rdata[SB_UNDERRUN]   = err_under;
        reg_rdata[SB_OVERRUN]    = err_over;
      end
      RA_THRESH: begin
        reg_rdata[AE_W-1:0]       = ae_thr;
        reg_rdata[AF_LSB +: AF_W] = af_thr;
      end
      RA_DATA: begin
        if (!busy && flg.not_empty) reg_rdata[DATA_W-1:0] = head;
      end
      RA_LEVEL: reg_rdata[COUNT_W-1:0] = COUNT_W'(lvl);
      RA_DEPTH: reg_rdata[COUNT_W-1:0] = COUNT_W'(DEPTH);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic             wbit_board,
  input logic             wbit_over,
  input logic [CNT_W-1:0] lvl,
  input logic             flag_not_full,
  input logic             rx_en,
  input logic             busy,
  input logic             push,
  input logic             pop,
  input logic             err_over,
  input logic             err_under
);

  logic ctrl_wr, over_clr_wr;
  assign ctrl_wr     = reg_wr && (reg_addr == RA_CTRL);
  assign over_clr_wr = reg_wr && (reg_addr == RA_STATUS) && wbit_over;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lvl) <= DEPTH);

  // R4
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_not_full |-> (32'(lvl) == DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ctrl_wr) |=> (lvl == CNT_W'($past(lvl) + 1'b1)));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rx_en && !busy && !flag_not_full && !ctrl_wr) |=> err_over);

  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (reg_addr == RA_DATA) && !busy && (lvl == '0)) |=> err_under);

  // R9
  sticky_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_over && !over_clr_wr && !(ctrl_wr && wbit_board)) |=> err_over);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R11
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wbit_board) |=> (busy && !err_under && !err_over && (lvl == '0)));

endmodule

bind rx_word_fifo rx_word_fifo_chk #(
  .DEPTH (DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .wbit_board    (reg_wdata[0]),
  .wbit_over     (reg_wdata[23]),
  .lvl           (lvl),
  .flag_not_full (flg.not_full),
  .rx_en         (rx_en),
  .busy          (busy),
  .push          (push),
  .pop           (pop),
  .err_over      (err_over),
  .err_under     (err_under)
);

// File: tb/rx_word_fifo_bench.sv
module rx_word_fifo_bench;

  localparam int DW    = 32;
  localparam int DEP   = 16;
  localparam int BUSYN = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [23:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cur_ae = 32;
  int cur_af = 32;

  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_THR = 3'd2,
                         A_DATA = 3'd3, A_LVL = 3'd4, A_DEP = 3'd5;

  always #5 clk = ~clk;

  rx_word_fifo #(.DATA_W(DW), .DEPTH(DEP), .BUSY_CYCLES(BUSYN)) u_rx_word_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] word_of(input int k);
    return {16'hC0DE, 16'(k)} ^ (32'(k) << 20);
  endfunction

  function automatic logic [31:0] exp_status(input int lvl, input int ae, input int af,
                                              input bit ov, input bit un);
    logic [31:0] s = '0;
    s[12] = (lvl > 0);
    s[13] = (lvl > ae);
    s[14] = (lvl + af < DEP);
    s[15] = (lvl < DEP);
    s[22] = un;
    s[23] = ov;
    return s;
  endfunction

  function automatic int ae_pick(input int i);
    case (i) 0: return 0; 1: return 5; 2: return 15; default: return 16; endcase
  endfunction

  function automatic int af_pick(input int i);
    case (i) 0: return 0; 1: return 3; 2: return 10; default: return 17; endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // All tasks start just after a falling edge and end just after one.
  task automatic reg_write(input logic [2:0] a, input logic [23:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop_word(output logic [31:0] d);
    reg_addr = A_DATA; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] e);
    logic [31:0] v;
    peek(a, v);
    check(tag, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1 ctrl", A_CTRL, 32'h0);
    expect_reg("R1 status", A_STAT, exp_status(0, 32, 32, 0, 0));
    expect_reg("R1 thresholds", A_THR, 32'h0020_0020);
    expect_reg("R3 level at reset", A_LVL, 32'd0);
    expect_reg("R3 depth", A_DEP, 32'(DEP));
    check("R2 ready low while disabled", {31'b0, in_ready}, 32'd0);

    // R2 enable receive
    reg_write(A_CTRL, 24'h20);
    expect_reg("R2 enable readback", A_CTRL, 32'h20);
    check("R2 ready when enabled", {31'b0, in_ready}, 32'd1);

    // R4 R5 R6 sweep over threshold pairs and every level
    for (int ia = 0; ia < 4; ia++) begin
      for (int ib = 0; ib < 4; ib++) begin
        int base = (ia * 4 + ib) * 32;
        cur_ae = ae_pick(ia);
        cur_af = af_pick(ib);
        reg_write(A_THR, {8'(cur_af), 16'(cur_ae)});
        expect_reg("R5 R6 threshold readback", A_THR, {8'h0, 8'(cur_af), 16'(cur_ae)});
        reg_write(A_CTRL, 24'h24);
        for (int k = 0; k < DEP; k++) begin
          expect_reg("R4 R5 R6 fill status", A_STAT, exp_status(k, cur_ae, cur_af, 0, 0));
          push_word(word_of(base + k));
        end
        expect_reg("R4 R5 R6 full status", A_STAT, exp_status(DEP, cur_ae, cur_af, 0, 0));
        expect_reg("R3 full level", A_LVL, 32'(DEP));
        check("R2 ready low when full", {31'b0, in_ready}, 32'd0);
        for (int k = 0; k < DEP; k++) begin
          expect_reg("R4 R5 R6 drain status", A_STAT, exp_status(DEP - k, cur_ae, cur_af, 0, 0));
          pop_word(v);
          check("R2 order", v, word_of(base + k));
        end
        expect_reg("R4 R5 R6 empty status", A_STAT, exp_status(0, cur_ae, cur_af, 0, 0));
      end
    end

    // R2 words while disabled are dropped without error
    reg_write(A_CTRL, 24'h00);
    push_word(32'hDEAD_0001);
    expect_reg("R2 disabled push level", A_LVL, 32'd0);
    expect_reg("R2 disabled push status", A_STAT, exp_status(0, cur_ae, cur_af, 0, 0));
    reg_write(A_CTRL, 24'h20);

    // R7 overrun
    for (int k = 0; k < DEP; k++) push_word(word_of(1000 + k));
    push_word(32'hBAD0_BAD0);
    expect_reg("R7 overrun status", A_STAT, exp_status(DEP, cur_ae, cur_af, 1, 0));
    expect_reg("R7 level kept", A_LVL, 32'(DEP));
    for (int k = 0; k < DEP; k++) begin
      pop_word(v);
      check("R7 stored words intact", v, word_of(1000 + k));
    end

    // R8 underrun
    pop_word(v);
    check("R8 empty read data", v, 32'd0);
    expect_reg("R8 level stays zero", A_LVL, 32'd0);
    expect_reg("R8 underrun status", A_STAT, exp_status(0, cur_ae, cur_af, 1, 1));

    // R9 write-one-to-clear
    reg_write(A_STAT, 24'h00_F000);
    expect_reg("R9 zeros keep errors", A_STAT, exp_status(0, cur_ae, cur_af, 1, 1));
    reg_write(A_STAT, 24'h40_0000);
    expect_reg("R9 clear underrun only", A_STAT, exp_status(0, cur_ae, cur_af, 1, 0));
    reg_write(A_STAT, 24'h80_0000);
    expect_reg("R9 clear overrun", A_STAT, exp_status(0, cur_ae, cur_af, 0, 0));
    for (int k = 0; k < DEP; k++) push_word(word_of(2000 + k));
    in_valid = 1'b1; in_data = 32'hBAD1_BAD1;
    reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 24'h80_0000;
    @(negedge clk);
    in_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    expect_reg("R9 set wins over clear", A_STAT, exp_status(DEP, cur_ae, cur_af, 1, 0));
    reg_write(A_STAT, 24'h80_0000);

    // R12 simultaneous push and pop
    reg_write(A_CTRL, 24'h24);
    for (int k = 0; k < 3; k++) push_word(word_of(3000 + k));
    in_valid = 1'b1; in_data = word_of(3003);
    reg_addr = A_DATA; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    in_valid = 1'b0; reg_rd = 1'b0;
    check("R12 head during overlap", v, word_of(3000));
    expect_reg("R12 level unchanged", A_LVL, 32'd3);
    for (int k = 1; k < 4; k++) begin
      pop_word(v);
      check("R12 order after overlap", v, word_of(3000 + k));
    end

    // R10 FIFO flush keeps settings and errors
    cur_ae = 4; cur_af = 7;
    reg_write(A_THR, 24'h07_0004);
    pop_word(v);
    for (int k = 0; k < 5; k++) push_word(word_of(4000 + k));
    reg_write(A_CTRL, 24'h24);
    expect_reg("R10 level cleared", A_LVL, 32'd0);
    expect_reg("R10 thresholds kept", A_THR, 32'h0007_0004);
    expect_reg("R10 flush bit self-clears", A_CTRL, 32'h20);
    expect_reg("R10 errors kept", A_STAT, exp_status(0, 4, 7, 0, 1));

    // R11 block reset and busy window
    push_word(word_of(5000));
    push_word(word_of(5001));
    reg_write(A_CTRL, 24'h01);
    expect_reg("R11 busy readback", A_CTRL, 32'h01);
    check("R11 ready low while busy", {31'b0, in_ready}, 32'd0);
    expect_reg("R11 level cleared", A_LVL, 32'd0);
    expect_reg("R11 thresholds restored", A_THR, 32'h0020_0020);
    expect_reg("R11 errors cleared", A_STAT, exp_status(0, 32, 32, 0, 0));
    pop_word(v);
    check("R11 busy read data", v, 32'd0);
    reg_write(A_CTRL, 24'h20);
    push_word(32'hBEEF_0000);
    expect_reg("R11 busy read no underrun", A_STAT, exp_status(0, 32, 32, 0, 0));
    expect_reg("R11 busy push dropped", A_LVL, 32'd0);
    repeat (BUSYN - 4) @(negedge clk);
    expect_reg("R11 still busy last cycle", A_CTRL, 32'h21);
    @(negedge clk);
    expect_reg("R11 busy ends", A_CTRL, 32'h20);
    check("R11 ready after busy", {31'b0, in_ready}, 32'd1);
    push_word(word_of(6000));
    expect_reg("R11 accepts after busy", A_LVL, 32'd1);

    summary();
  end

endmodule